// File: doc/BRIEF.md
# I2C Bus State and Hang Monitor

This block observes the SCL and SDA lines of an I2C bus and reports what the bus is doing. It never drives either line. Both lines go through a synchronizer. On the synchronized samples the block detects START and STOP conditions and tracks whether the bus is busy. It raises a sticky error when a START or STOP falls inside a byte or its acknowledge bit. It also reports a hang when SCL stays high for too long while SDA is held low.

A second function is an idle timeout. A programmable count of sample ticks begins once every event flag has been cleared. If software leaves the bus untouched for that many ticks, a timeout flag is raised. The transfer engine supplies a frame-span input that marks where a START or STOP would be misplaced. Software clears each event flag by pulsing its own clear strobe.

The bus state machine has two states, `BUS_IDLE` and `BUS_BUSY`. Its transitions are:
- idle-to-busy on a START;
- busy-to-idle on a STOP;
- busy-to-busy on a repeated START.

A STOP seen in `BUS_IDLE` leaves the machine in `BUS_IDLE`.

Top module: `i2c_bus_watch`

## Requirements
- R1: A falling SDA while SCL is high, both taken after the two-stage synchronizer, sets `start_flag`. The flag stays set until a cycle with `clr_start` high.
- R2: A rising SDA while SCL is high sets `stop_flag`. The flag stays set until a cycle with `clr_stop` high.
- R3: `bus_busy` is low after reset. It goes high on a START, stays high across a repeated START, and goes low on a STOP.
- R4: A START or STOP seen while `in_frame` is high sets `err_flag`, which stays set until `clr_err`. A START or STOP seen with `in_frame` low leaves `err_flag` low.
- R5: A 4-bit hang counter advances on each `samp_tick` taken while SCL is high, and any SCL falling edge returns it to zero. If the 16th such tick after a falling edge arrives while SDA is low, `bus_hang` goes high.
- R6: When the hang counter overflows with SDA high, `bus_hang` stays low.
- R7: `bus_hang` clears on the next START condition. A STOP does not clear it.
- R8: The timeout counter runs only while all four event flags are clear and `to_limit` is non-zero. For a non-zero `to_limit` of N, `to_flag` goes high on the N-th `samp_tick` after that point. It stays high until `clr_to`.
- R9: With `to_limit` equal to zero, `to_flag` never rises.
- R10: While any of the four event flags is set, the timeout counter is held at zero, so no timeout can complete.
- R11: Each clear strobe clears only its own flag: bit order start, stop, error, timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Unsynchronized SCL line level |
| sda_raw | input | 1 | Unsynchronized SDA line level |
| samp_tick | input | 1 | One-cycle sample tick for the hang and timeout counters |
| in_frame | input | 1 | High from the first address bit through the acknowledge bit |
| to_limit | input | 10 | Timeout length in ticks; zero disables the timeout |
| clr_start | input | 1 | Clears `start_flag` |
| clr_stop | input | 1 | Clears `stop_flag` |
| clr_err | input | 1 | Clears `err_flag` |
| clr_to | input | 1 | Clears `to_flag` |
| start_flag | output | 1 | Sticky START seen |
| stop_flag | output | 1 | Sticky STOP seen |
| err_flag | output | 1 | Sticky misplaced START/STOP |
| to_flag | output | 1 | Sticky idle timeout |
| bus_busy | output | 1 | Bus is between START and STOP |
| bus_hang | output | 1 | SCL held high with SDA low through a full hang count |

## Verification
Some rules can be checked on every cycle, and the assertions cover these:
- flags persist until their clear strobe arrives;
- the state machine follows START and STOP;
- a START always drops `bus_hang`;
- a hang can only be raised with SDA low;
- a timeout cannot rise from a zero limit.

Other behaviour needs a deliberate sequence, and only the bench scenarios show it:
- the exact tick on which a hang or timeout fires;
- the counter restarting after an SCL falling edge;
- overflow with SDA high staying harmless;
- the timeout being held off by a pending flag.

The bench sweeps the timeout limit from 1 to 12 and checks the firing tick for each value arithmetically.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_watch_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output line_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prev;

    assign raw = {sda_raw, scl_raw};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] sh;
            logic              pv;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= '1;
                    pv <= 1'b1;
                end else begin
                    sh <= {sh[STAGES-2:0], raw[g]};
                    pv <= sh[TOP];
                end
            end
            assign cur[g]  = sh[TOP];
            assign prev[g] = pv;
        end
    endgenerate

    always_comb begin
        ev.scl      = cur[LINE_SCL];
        ev.sda      = cur[LINE_SDA];
        ev.scl_fall = prev[LINE_SCL] & ~cur[LINE_SCL];
        ev.start    = prev[LINE_SCL] & cur[LINE_SCL] & prev[LINE_SDA] & ~cur[LINE_SDA];
        ev.stop     = prev[LINE_SCL] & cur[LINE_SCL] & ~prev[LINE_SDA] & cur[LINE_SDA];
    end

endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
    import i2c_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic in_frame,
    input  logic clr_start,
    input  logic clr_stop,
    input  logic clr_err,
    output logic bus_busy,
    output logic start_flag,
    output logic stop_flag,
    output logic err_flag
);
    bus_state_e state, nxt;
    logic       misplaced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BUS_IDLE: if (ev_start) nxt = BUS_BUSY;
            BUS_BUSY: if (ev_stop)  nxt = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_busy  = (state == BUS_BUSY);
        misplaced = in_frame & (ev_start | ev_stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            if (ev_start)       start_flag <= 1'b1;
            else if (clr_start) start_flag <= 1'b0;
            if (ev_stop)        stop_flag  <= 1'b1;
            else if (clr_stop)  stop_flag  <= 1'b0;
            if (misplaced)      err_flag   <= 1'b1;
            else if (clr_err)   err_flag   <= 1'b0;
        end
    end

    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> bus_busy);
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> !bus_busy);
    a_r1_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !clr_start) |=> start_flag);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag);
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(in_frame));

endmodule

// File: rtl/i2c_hang_det.sv
module i2c_hang_det #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl,
    input  logic sda,
    input  logic scl_fall,
    input  logic ev_start,
    output logic bus_hang
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             adv;
    logic             wrap;

    always_comb begin
        adv  = tick & scl & ~scl_fall;
        wrap = adv & (cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bus_hang <= 1'b0;
        end else begin
            if (scl_fall) cnt <= '0;
            else if (adv) cnt <= cnt + 1'b1;
            if (ev_start)          bus_hang <= 1'b0;
            else if (wrap && !sda) bus_hang <= 1'b1;
        end
    end

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !bus_hang);
    a_r5_hang_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hang) |-> !$past(sda));
    a_r5_fall_restart: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> (cnt == '0));

endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
    parameter int TO_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [TO_W-1:0] limit,
    input  logic            any_flag,
    input  logic            clr_to,
    output logic            to_flag
);
    logic [TO_W-1:0] cnt;
    logic [TO_W:0]   cnt_nx;
    logic            hold;

    always_comb begin
        cnt_nx = {1'b0, cnt} + 1'b1;
        hold   = any_flag | (limit == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            to_flag <= 1'b0;
        end else begin
            if (clr_to) to_flag <= 1'b0;
            if (hold) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt_nx == {1'b0, limit}) begin
                    to_flag <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt_nx[TO_W-1:0];
                end
            end
        end
    end

    a_r9_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> ($past(limit) != '0));
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |=> (cnt == '0));
    a_r8_to_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !clr_to) |=> to_flag);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HANG_W      = 4,
    parameter int TO_W        = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_raw,
    input  logic            sda_raw,
    input  logic            samp_tick,
    input  logic            in_frame,
    input  logic [TO_W-1:0] to_limit,
    input  logic            clr_start,
    input  logic            clr_stop,
    input  logic            clr_err,
    input  logic            clr_to,
    output logic            start_flag,
    output logic            stop_flag,
    output logic            err_flag,
    output logic            to_flag,
    output logic            bus_busy,
    output logic            bus_hang
);
    line_ev_t ev;
    logic     any_flag;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_raw),
        .sda_raw (sda_raw),
        .ev      (ev)
    );

    i2c_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (ev.start),
        .ev_stop    (ev.stop),
        .in_frame   (in_frame),
        .clr_start  (clr_start),
        .clr_stop   (clr_stop),
        .clr_err    (clr_err),
        .bus_busy   (bus_busy),
        .start_flag (start_flag),
        .stop_flag  (stop_flag),
        .err_flag   (err_flag)
    );

    i2c_hang_det #(.CNT_W(HANG_W)) u_hang (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (samp_tick),
        .scl      (ev.scl),
        .sda      (ev.sda),
        .scl_fall (ev.scl_fall),
        .ev_start (ev.start),
        .bus_hang (bus_hang)
    );

    assign any_flag = start_flag | stop_flag | err_flag | to_flag;

    i2c_idle_timer #(.TO_W(TO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (samp_tick),
        .limit    (to_limit),
        .any_flag (any_flag),
        .clr_to   (clr_to),
        .to_flag  (to_flag)
    );

    a_r11_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && !clr_stop && stop_flag && !ev.stop) |=> stop_flag);

endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       samp_tick = 1'b0;
    logic       in_frame = 1'b0;
    logic [9:0] to_limit = '0;
    logic       clr_start = 1'b0, clr_stop = 1'b0, clr_err = 1'b0, clr_to = 1'b0;
    logic       start_flag, stop_flag, err_flag, to_flag, bus_busy, bus_hang;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2c_bus_watch i_i2c_bus_watch (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .samp_tick(samp_tick), .in_frame(in_frame), .to_limit(to_limit),
        .clr_start(clr_start), .clr_stop(clr_stop), .clr_err(clr_err), .clr_to(clr_to),
        .start_flag(start_flag), .stop_flag(stop_flag), .err_flag(err_flag),
        .to_flag(to_flag), .bus_busy(bus_busy), .bus_hang(bus_hang)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic lines(input logic c, input logic d);
        scl_raw = c;
        sda_raw = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            samp_tick = 1'b1;
            @(negedge clk);
            samp_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clr(input logic [3:0] m);
        {clr_to, clr_err, clr_stop, clr_start} = m;
        @(negedge clk);
        {clr_to, clr_err, clr_stop, clr_start} = 4'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset start_flag", start_flag, 1'b0);
        chk("R2 reset stop_flag", stop_flag, 1'b0);
        chk("R3 reset bus_busy", bus_busy, 1'b0);
        chk("R4 reset err_flag", err_flag, 1'b0);
        chk("R5 reset bus_hang", bus_hang, 1'b0);
        chk("R8 reset to_flag", to_flag, 1'b0);

        // R6: idle lines, overflow with SDA high
        ticks(20);
        chk("R6 overflow with SDA high", bus_hang, 1'b0);

        // START outside a frame
        lines(1, 0);
        chk("R1 start sets flag", start_flag, 1'b1);
        chk("R3 busy after start", bus_busy, 1'b1);
        chk("R4 start outside frame", err_flag, 1'b0);
        clr(4'b0001);
        chk("R1 clr_start clears", start_flag, 1'b0);

        // R5: counter restart on SCL fall, then exact overflow tick
        ticks(10);
        lines(0, 0);
        lines(1, 0);
        ticks(15);
        chk("R5 no hang after 15 ticks", bus_hang, 1'b0);
        ticks(1);
        chk("R5 hang on 16th tick", bus_hang, 1'b1);

        // STOP keeps hang, START clears it
        lines(1, 1);
        chk("R2 stop sets flag", stop_flag, 1'b1);
        chk("R3 idle after stop", bus_busy, 1'b0);
        chk("R7 stop keeps hang", bus_hang, 1'b1);
        lines(1, 0);
        chk("R7 start clears hang", bus_hang, 1'b0);
        chk("R3 busy again", bus_busy, 1'b1);
        clr(4'b0011);
        chk("R2 clr_stop clears", stop_flag, 1'b0);

        // repeated START
        lines(0, 0);
        lines(0, 1);
        lines(1, 1);
        chk("R3 no event on SCL rise", stop_flag, 1'b0);
        lines(1, 0);
        chk("R3 busy through repeated start", bus_busy, 1'b1);
        chk("R1 repeated start flag", start_flag, 1'b1);

        // misplaced STOP
        in_frame = 1'b1;
        lines(0, 0);
        lines(1, 0);
        lines(1, 1);
        chk("R4 stop in frame", err_flag, 1'b1);
        chk("R3 idle after framed stop", bus_busy, 1'b0);
        in_frame = 1'b0;
        clr(4'b0100);
        chk("R4 clr_err clears", err_flag, 1'b0);
        chk("R11 clr_err leaves stop_flag", stop_flag, 1'b1);
        chk("R11 clr_err leaves start_flag", start_flag, 1'b1);

        // misplaced START
        in_frame = 1'b1;
        lines(1, 0);
        chk("R4 start in frame", err_flag, 1'b1);
        in_frame = 1'b0;
        clr(4'b0111);
        lines(0, 0);
        lines(1, 0);
        lines(1, 1);
        chk("R4 stop outside frame", err_flag, 1'b0);
        chk("R2 stop outside frame sets", stop_flag, 1'b1);

        // R8: sweep over timeout limits
        for (int lim = 1; lim <= 12; lim++) begin
            to_limit = 10'(lim);
            clr(4'b1111);
            ticks(lim - 1);
            chk("R8 no timeout before limit", to_flag, 1'b0);
            ticks(1);
            chk("R8 timeout at limit", to_flag, 1'b1);
            ticks(3);
            chk("R8 timeout stays set", to_flag, 1'b1);
        end
        clr(4'b1000);
        chk("R11 clr_to clears", to_flag, 1'b0);

        // R10: a pending flag blocks the timeout
        to_limit = 10'd5;
        lines(1, 0);
        clr(4'b1110);
        ticks(10);
        chk("R10 pending flag holds timer", to_flag, 1'b0);
        clr(4'b0001);
        ticks(4);
        chk("R10 timer runs after clear, 4 ticks", to_flag, 1'b0);
        ticks(1);
        chk("R10 timer fires on 5th tick", to_flag, 1'b1);

        // R9: zero limit
        to_limit = '0;
        clr(4'b1111);
        ticks(40);
        chk("R9 zero limit never fires", to_flag, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule